// File: doc/BRIEF.md
# Synchronous Slave FIFO Write Sequencer

This block is the controlling side of a write port into a synchronous slave FIFO that shares one interface clock with it. A local producer hands it data words over a valid/ready handshake, and each word carries a flag that marks the end of a packet. The block then drives the FIFO bus. It places the target FIFO address and the select, holds off the write strobe until the address has had time to settle, and after that streams one word per cycle for as long as the producer keeps up and the FIFO has room. It marks short packets with a packet-end pulse.

The FIFO commits a packet by itself each time its word count reaches a configured auto length. The block keeps its own count of words modulo that length, so it knows which packets need a manual packet-end. A short packet normally gets its packet-end on the same edge as its last word. There is one exception: a one-word packet that directly follows an auto-committed packet. For that case the packet-end is given on its own cycle, after the edge that wrote the word. While the FIFO reports full, the strobe is withdrawn and the pending word stays on the bus.

Top module: `slave_fifo_writer`

## Requirements
- R1: After reset, bus_sel_n, bus_wstb_n and bus_commit_n are high (inactive) and src_ready is low.
- R2: bus_addr is loaded from cfg_addr on the edge that leaves idle. It does not change while bus_sel_n stays low, and this includes every cycle in which bus_commit_n is low.
- R3: bus_wstb_n is low only when bus_sel_n is low in that cycle and was also low in the previous cycle.
- R4: The first write of a run happens no sooner than the third rising edge after the request is seen in idle. The address and select are therefore driven for at least two full cycles before the first write edge.
- R5: Every accepted word is written exactly once, in acceptance order. A write is a rising edge on which both bus_sel_n and bus_wstb_n are low.
- R6: When src_valid is held high and fifo_full is low, words are written on consecutive edges with no gap.
- R7: While fifo_full is high, bus_wstb_n is high. The pending word is kept and is written once fifo_full falls.
- R8: Consider a word with src_last set that does not bring the running word count to cfg_auto_len, and that is not a deferred case (R10). That word is written with bus_commit_n low on the same edge.
- R9: A packet whose last word brings the running word count exactly to cfg_auto_len gets no packet-end. The count restarts from zero after each auto commit and after each manual commit.
- R10: A one-word short packet that directly follows an auto commit is written with bus_commit_n high. On the next cycle bus_commit_n is low, bus_wstb_n is high and src_ready is low.
- R11: When no word is pending and src_valid is low, the block returns to idle and bus_sel_n goes high. src_ready is low whenever bus_sel_n is high.
- R12: A change of cfg_addr while bus_sel_n is low has no effect on bus_addr until the next run starts from idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared interface clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_addr | input | ADDR_W | FIFO address used for the next run |
| cfg_auto_len | input | LEN_W | Word count at which the FIFO auto-commits a packet |
| src_valid | input | 1 | Producer has a word |
| src_ready | output | 1 | Block takes the word on this edge |
| src_data | input | DATA_W | Producer word |
| src_last | input | 1 | Word closes a packet |
| fifo_full | input | 1 | FIFO has no room; a write is not allowed |
| bus_addr | output | ADDR_W | FIFO address lines |
| bus_sel_n | output | 1 | FIFO select, active low |
| bus_wstb_n | output | 1 | Write strobe, active low |
| bus_wdata | output | DATA_W | Write data lines |
| bus_commit_n | output | 1 | Packet-end, active low |

## Verification
If the word counter drifts, the fault shows up at the first packet end after the drift. A short packet loses its packet-end, an exact-length packet gains one, or a deferred commit appears on the wrong packet. The scoreboard, which tracks the count independently, catches each of these on that same write edge. A stuck sequencing state shows within a cycle or two: the strobe comes before the select has settled, the select never drops, or the strobe stays asserted while the FIFO is full. If the pending word is dropped or duplicated, the next write no longer matches the queue.

// File: rtl/sfw_pkg.sv
// Shared types for the slave FIFO write sequencer.
package sfw_pkg;
    // Bus phases: idle, address/select settling, word streaming.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_RUN   = 2'd2
    } sfw_state_t;
endpackage

// File: rtl/sfw_pkt_track.sv
// Running word counter modulo the auto-commit length.
// It decides whether the word now on the bus carries its own packet-end,
// or whether it needs a packet-end on a separate later cycle.
// Assumes: word_done pulses once per written word; cfg_len is stable
// while packets are in flight.
module sfw_pkt_track #(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic             word_done,
    input  logic             word_last,
    output logic             cmt_with_word,
    output logic             cmt_deferred
);
    logic [LEN_W-1:0] cnt_q;
    logic             after_auto_q;
    logic [LEN_W-1:0] cnt_next;
    logic             hits_len;
    logic             short_end;
    logic             lone_after_auto;

    // Decode what the current bus word means for the packet boundary.
    always_comb begin
        cnt_next        = cnt_q + 1'b1;
        hits_len        = (cnt_next == cfg_len);
        short_end       = word_last && !hits_len;
        lone_after_auto = (cnt_q == '0) && after_auto_q;
        cmt_with_word   = short_end && !lone_after_auto;
        cmt_deferred    = short_end && lone_after_auto;
    end

    // Advance the count and remember whether the last word closed an auto packet.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q        <= '0;
            after_auto_q <= 1'b0;
        end else if (word_done) begin
            cnt_q        <= (hits_len || word_last) ? '0 : cnt_next;
            after_auto_q <= hits_len;
        end
    end
endmodule

// File: rtl/sfw_out_stage.sv
// Single-entry output register that holds the word driven on the bus.
// Assumes: load and drop may coincide; load wins and refills the slot.
module sfw_out_stage #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    input  logic              drop,
    output logic [DATA_W-1:0] out_data,
    output logic              out_last,
    output logic              pend
);
    // Capture a new word, or empty the slot once its word is written.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data <= '0;
            out_last <= 1'b0;
            pend     <= 1'b0;
        end else if (load) begin
            out_data <= in_data;
            out_last <= in_last;
            pend     <= 1'b1;
        end else if (drop) begin
            pend     <= 1'b0;
        end
    end
endmodule

// File: rtl/sfw_bus_fsm.sv
// Bus phase sequencer. It latches the address when leaving idle, then
// spends one settle cycle with select asserted before streaming begins.
// It also issues the stand-alone packet-end cycle and returns to idle
// once nothing is pending.
// Assumes: defer_hit is only meaningful together with word_done.
module sfw_bus_fsm
    import sfw_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic              src_valid,
    input  logic              pend,
    input  logic              word_done,
    input  logic              defer_hit,
    output logic [ADDR_W-1:0] addr_q,
    output logic              run,
    output logic              selected,
    output logic              lone_cmt_q
);
    sfw_state_t state_q;

    // Phase transitions and address capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (src_valid) begin
                    state_q <= ST_SETUP;
                    addr_q  <= cfg_addr;
                end
                ST_SETUP: state_q <= ST_RUN;
                ST_RUN: if (!pend && !lone_cmt_q && !src_valid)
                    state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Stand-alone packet-end cycle after a deferred one-word packet.
    always_ff @(posedge clk) begin
        if (!rst_n) lone_cmt_q <= 1'b0;
        else        lone_cmt_q <= word_done && defer_hit;
    end

    // Phase decode for the datapath.
    always_comb begin
        run      = (state_q == ST_RUN);
        selected = (state_q != ST_IDLE);
    end
endmodule

// File: rtl/slave_fifo_writer.sv
// Write-side controller for a synchronous slave FIFO.
// It turns a valid/ready word stream with an end-of-packet flag into
// address, select, strobe, data and packet-end signals on the shared clock.
// Assumes: the FIFO samples on the rising edge, and fifo_full is valid
// before that edge.
module slave_fifo_writer #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 2,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [LEN_W-1:0]  cfg_auto_len,
    input  logic              src_valid,
    output logic              src_ready,
    input  logic [DATA_W-1:0] src_data,
    input  logic              src_last,
    input  logic              fifo_full,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_sel_n,
    output logic              bus_wstb_n,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_commit_n
);
    logic pend, run, selected, lone_cmt_q;
    logic word_done, load, out_last;
    logic cmt_with_word, cmt_deferred;
    logic [ADDR_W-1:0] addr_q;

    // Handshake and bus strobe decode.
    always_comb begin
        word_done    = run && pend && !fifo_full;
        src_ready    = run && !lone_cmt_q && (!pend || (!fifo_full && !cmt_deferred));
        load         = src_valid && src_ready;
        bus_addr     = addr_q;
        bus_sel_n    = !selected;
        bus_wstb_n   = !word_done;
        bus_commit_n = !((word_done && cmt_with_word) || lone_cmt_q);
    end

    sfw_bus_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_addr   (cfg_addr),
        .src_valid  (src_valid),
        .pend       (pend),
        .word_done  (word_done),
        .defer_hit  (cmt_deferred),
        .addr_q     (addr_q),
        .run        (run),
        .selected   (selected),
        .lone_cmt_q (lone_cmt_q)
    );

    sfw_out_stage #(.DATA_W(DATA_W)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .in_data  (src_data),
        .in_last  (src_last),
        .drop     (word_done),
        .out_data (bus_wdata),
        .out_last (out_last),
        .pend     (pend)
    );

    sfw_pkt_track #(.LEN_W(LEN_W)) u_trk (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_len       (cfg_auto_len),
        .word_done     (word_done),
        .word_last     (out_last),
        .cmt_with_word (cmt_with_word),
        .cmt_deferred  (cmt_deferred)
    );
endmodule

// File: rtl/slave_fifo_writer_chk.sv
// Port-level ordering checks for the slave FIFO write sequencer.
module slave_fifo_writer_chk #(
    parameter int ADDR_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fifo_full,
    input logic              src_ready,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_sel_n,
    input logic              bus_wstb_n,
    input logic              bus_commit_n
);
    AST_SEL_LEADS_STB: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wstb_n |-> (!bus_sel_n && $past(!bus_sel_n))); // R3

    AST_ADDR_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_sel_n && $past(!bus_sel_n)) |-> $stable(bus_addr)); // R2

    AST_SETTLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_sel_n) |=> bus_wstb_n); // R4

    AST_NO_WRITE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> bus_wstb_n); // R7

    AST_LONE_COMMIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_commit_n && bus_wstb_n) |-> !src_ready); // R10

    AST_READY_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        src_ready |-> !bus_sel_n); // R11
endmodule

bind slave_fifo_writer slave_fifo_writer_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .fifo_full    (fifo_full),
    .src_ready    (src_ready),
    .bus_addr     (bus_addr),
    .bus_sel_n    (bus_sel_n),
    .bus_wstb_n   (bus_wstb_n),
    .bus_commit_n (bus_commit_n)
);

// File: tb/slave_fifo_writer_test.sv
module slave_fifo_writer_test;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;
    localparam int AW = 2;
    localparam int LW = 8;
    localparam int AUTO = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic [LW-1:0] cfg_auto_len = LW'(AUTO);
    logic src_valid = 1'b0;
    logic [DW-1:0] src_data = '0;
    logic src_last = 1'b0;
    logic fifo_full = 1'b0;
    logic src_ready, bus_sel_n, bus_wstb_n, bus_commit_n;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct packed {
        logic          lone;
        logic          cmt;
        logic [DW-1:0] data;
    } exp_t;
    exp_t q[$];

    int mcnt = 0;
    bit mprev = 1'b0;
    logic [AW-1:0] exp_addr = '0;
    int streak = 0;
    int streak_max = 0;
    int sel_age = 0;
    int full_seen = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    slave_fifo_writer #(.DATA_W(DW), .ADDR_W(AW), .LEN_W(LW)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_auto_len(cfg_auto_len),
        .src_valid(src_valid), .src_ready(src_ready), .src_data(src_data),
        .src_last(src_last), .fifo_full(fifo_full), .bus_addr(bus_addr),
        .bus_sel_n(bus_sel_n), .bus_wstb_n(bus_wstb_n), .bus_wdata(bus_wdata),
        .bus_commit_n(bus_commit_n)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Driver: predict the packet boundary outcome, queue it, then hand the word over.
    task automatic send(input logic [DW-1:0] d, input bit last);
        int n;
        exp_t e;
        n = mcnt + 1;
        e.lone = 1'b0; e.data = d; e.cmt = 1'b0;
        if (last && n != AUTO) begin
            if (mcnt == 0 && mprev) begin
                q.push_back(e);
                e.lone = 1'b1;
                q.push_back(e);
            end else begin
                e.cmt = 1'b1;
                q.push_back(e);
            end
        end else begin
            q.push_back(e);
        end
        mprev = (n == AUTO);
        mcnt = (n == AUTO || last) ? 0 : n;
        @(negedge clk);
        src_valid = 1'b1; src_data = d; src_last = last;
        #1;
        while (!src_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
    endtask

    task automatic go_idle(input int cycles);
        @(negedge clk);
        src_valid = 1'b0;
        repeat (cycles) @(negedge clk);
    endtask

    // Monitor: compare every write edge and every lone packet-end with the queue.
    always begin
        exp_t e;
        @(negedge clk);
        #2;
        if (rst_n && !done) begin
            if (fifo_full) begin
                full_seen++;
                check(bus_wstb_n == 1'b1, "R7 strobe while full", int'(bus_wstb_n), 1);
            end
            if (!bus_sel_n && !bus_wstb_n) begin
                streak++;
                if (streak > streak_max) streak_max = streak;
                check(sel_age >= 2, "R4 settle before write", sel_age, 2);
                check(bus_addr == exp_addr, "R2 R12 address", int'(bus_addr), int'(exp_addr));
                if (q.size() == 0) begin
                    check(1'b0, "R5 unexpected write", int'(bus_wdata), -1);
                end else begin
                    e = q.pop_front();
                    check(!e.lone, "R10 write where lone commit expected", 1, 0);
                    check(bus_wdata == e.data, "R5 data order", int'(bus_wdata), int'(e.data));
                    check(!bus_commit_n == e.cmt, "R8 R9 packet-end with word",
                          int'(!bus_commit_n), int'(e.cmt));
                end
            end else begin
                streak = 0;
                if (!bus_commit_n) begin
                    check(!src_ready, "R10 ready during lone commit", int'(src_ready), 0);
                    check(bus_addr == exp_addr, "R2 address during commit",
                          int'(bus_addr), int'(exp_addr));
                    if (q.size() == 0) begin
                        check(1'b0, "R10 unexpected lone commit", 1, 0);
                    end else begin
                        e = q.pop_front();
                        check(e.lone, "R10 lone commit", 1, int'(e.lone));
                    end
                end
            end
            sel_age = bus_sel_n ? 0 : sel_age + 1;
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            check(1'b0, "watchdog", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        #2;
        check(bus_sel_n && bus_wstb_n && bus_commit_n, "R1 bus idle after reset",
              int'({bus_sel_n, bus_wstb_n, bus_commit_n}), 7);
        check(!src_ready, "R1 ready after reset", int'(src_ready), 0);

        // Single short word: packet-end with the word (R8), settle cycles (R4).
        cfg_addr = 2'd1; exp_addr = 2'd1;
        send(16'h0A01, 1'b1);
        go_idle(5);
        #2;
        check(bus_sel_n == 1'b1, "R11 select released", int'(bus_sel_n), 1);
        check(!src_ready, "R11 ready when idle", int'(src_ready), 0);

        // Exact-length burst: no packet-end (R9), back-to-back writes (R6).
        streak_max = 0;
        for (int i = 0; i < AUTO; i++) send(16'h0B00 + 16'(i), i == AUTO-1);
        go_idle(5);
        check(streak_max == AUTO, "R6 burst writes per cycle", streak_max, AUTO);

        // Lone word after auto commit: deferred packet-end (R10).
        send(16'h0C01, 1'b1);
        go_idle(5);

        // Auto packet inside a burst, lone word, then a 3-word short packet (R10 R8).
        for (int i = 0; i < AUTO; i++) send(16'h0D00 + 16'(i), 1'b0);
        send(16'h0D10, 1'b1);
        for (int i = 0; i < 3; i++) send(16'h0D20 + 16'(i), i == 2);
        go_idle(5);

        // Full stall mid-burst plus an address change while selected (R7 R12).
        full_seen = 0;
        fork
            for (int i = 0; i < 6; i++) send(16'h0E00 + 16'(i), i == 5);
            begin
                repeat (4) @(negedge clk);
                fifo_full = 1'b1;
                cfg_addr = 2'd3;
                repeat (3) @(negedge clk);
                fifo_full = 1'b0;
            end
        join
        go_idle(6);
        check(full_seen >= 3, "R7 stall exercised", full_seen, 3);

        // New address is taken only through a fresh run (R12 R2).
        exp_addr = 2'd3;
        send(16'h0F01, 1'b1);
        go_idle(6);

        check(q.size() == 0, "R5 all words written", q.size(), 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule